// File: doc/BRIEF.md
# Block-Granular Write Protection Sequencer

This block sits in front of the byte-write port of a small nonvolatile memory model (13-bit address, 8-bit data). It watches every write strobe, recognises fixed address/data command sequences, and decides for each write whether it may reach the array. Two protection levels are kept. The first is a global protection flag: while it is set, data writes are accepted only inside a window opened by a three-byte arming sequence. The second is an 8-bit lock mask with one bit per 1K-byte block: a locked block refuses writes even inside an armed window. Command bytes are consumed by the block and never reach the array.

The sequence matcher is a single enumerated state machine. Its states are: `ST_IDLE` (no sequence in progress), `ST_G1` (first command byte seen), `ST_G2` (second command byte seen), `ST_ARMED` (write window open), `ST_L4` (fourth byte of the lock-open sequence seen), `ST_LOPEN` (the next write loads the lock mask), and `ST_D3`, `ST_D4`, `ST_D5` (steps of the deactivation sequence). The transitions are: IDLE→G1 on AA/555; G1→G2 on 55/AAA; G2→ARMED on A0/555, which also sets protection; G2→D3 on 80/555; ARMED→ARMED on any data write; ARMED→L4 on AA/555; L4→LOPEN on C0/AAA; LOPEN→IDLE on any write, which loads the mask; D3→D4 on AA/555; D4→D5 on 55/AAA; D5→IDLE on 20/555, which clears protection. Any other write in a non-idle state is a mismatch and is handled as if it arrived in IDLE. From any non-idle state, a gap of `WIN_CYC` clock cycles with no write returns the machine to IDLE (timeout).

The write-permit decision comes out as a one-cycle pulse registered on the clock edge that takes the write. The current lock mask and the protection flag are outputs as well.

Top module: `wprot_seq`

## Requirements
- R1: After reset `prot_on` is 0, `lock_mask` equals `LOCK_RST` (default all zero), and `wr_permit` is 0.
- R2: `wr_permit` is 1 for exactly the cycle after a write is taken, and only for a write that is allowed. While `prot_on` is 0, an ordinary data write to an unlocked block is allowed.
- R3: Command matching compares only `wr_addr[11:0]` against 0x555 and 0xAAA. `wr_addr[12]` has no effect on matching.
- R4: The sequence AA to 0x555, 55 to 0xAAA, A0 to 0x555 sets `prot_on` to 1 and opens a write window. Data writes in the window are allowed unless their block is locked. Command-sequence writes are never allowed.
- R5: While `prot_on` is 1, a data write outside an open window is refused.
- R6: The window stays open across a gap of `WIN_CYC`-1 idle cycles between writes. After `WIN_CYC` idle cycles it closes and the machine returns to idle.
- R7: A write that breaks an expected step returns the matcher to idle and is judged as in idle. A non-command write with protection off is then allowed.
- R8: The sequence AA/0x555, 55/0xAAA, A0/0x555, AA/0x555, C0/0xAAA makes the next write, to any address, load `lock_mask` from `wr_data[7:0]`. That write is not allowed.
- R9: `lock_mask` bit n locks the block whose address bits `[12:10]` equal n (addresses n×0x400 to n×0x400+0x3FF), where 1 means locked. A write to a locked block is refused even inside an armed window.
- R10: The sequence AA/0x555, 55/0xAAA, 80/0x555, AA/0x555, 55/0xAAA, 20/0x555 clears `prot_on`. The lock mask keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe; one write per cycle in which it is high |
| wr_addr | input | 13 | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| wr_permit | output | 1 | Pulse: the write taken on the last edge may reach the array |
| lock_mask | output | 8 | Per-block lock bits, 1 = locked |
| prot_on | output | 1 | Global protection flag |

## Verification
The bench builds the block with `WIN_CYC` = 16, 8 blocks and a 13-bit address. The short window lets it place writes exactly 15 and 16 idle cycles apart, so both sides of the timeout edge are checked within a few dozen cycles. With eight blocks of 1K bytes, the first and last bytes of blocks 0, 1, 6 and 7 can be aimed at to probe the lock-bit boundaries. Command addresses with bit 12 set are used to show that the high bit is ignored.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    // Width of the address slice compared against command addresses.
    localparam int CMD_AW = 12;
    localparam logic [CMD_AW-1:0] CMD_ADDR_LO = 12'h555;
    localparam logic [CMD_AW-1:0] CMD_ADDR_HI = 12'hAAA;

    localparam logic [7:0] KEY_START  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] KEY_ARM    = 8'hA0;
    localparam logic [7:0] KEY_LOCK   = 8'hC0;
    localparam logic [7:0] KEY_DEACT  = 8'h80;
    localparam logic [7:0] KEY_FINAL  = 8'h20;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_G1,
        ST_G2,
        ST_ARMED,
        ST_L4,
        ST_LOPEN,
        ST_D3,
        ST_D4,
        ST_D5
    } seq_state_t;

    typedef struct packed {
        logic start_lo;   // AA to 0x555
        logic second_hi;  // 55 to 0xAAA
        logic arm_lo;     // A0 to 0x555
        logic lock_hi;    // C0 to 0xAAA
        logic deact_lo;   // 80 to 0x555
        logic final_lo;   // 20 to 0x555
    } cmd_hit_t;

endpackage

// File: rtl/wprot_cmd_match.sv
module wprot_cmd_match
    import wprot_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output cmd_hit_t          hit
);

    logic [CMD_AW-1:0] a_lo;
    logic              at_lo;
    logic              at_hi;

    // Only the low command slice takes part; higher bits are ignored.
    assign a_lo  = addr[CMD_AW-1:0];
    assign at_lo = (a_lo == CMD_ADDR_LO);
    assign at_hi = (a_lo == CMD_ADDR_HI);

    always_comb begin
        hit.start_lo  = at_lo && (data == DATA_W'(KEY_START));
        hit.second_hi = at_hi && (data == DATA_W'(KEY_SECOND));
        hit.arm_lo    = at_lo && (data == DATA_W'(KEY_ARM));
        hit.lock_hi   = at_hi && (data == DATA_W'(KEY_LOCK));
        hit.deact_lo  = at_lo && (data == DATA_W'(KEY_DEACT));
        hit.final_lo  = at_lo && (data == DATA_W'(KEY_FINAL));
    end

endmodule

// File: rtl/wprot_gap_timer.sv
module wprot_gap_timer #(
    parameter int WIN_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic wr_seen,
    output logic expired
);

    localparam int CNT_W = $clog2(WIN_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYC - 1);

    logic [CNT_W-1:0] gap_cnt;

    assign expired = active && !wr_seen && (gap_cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (wr_seen || !active) begin
            gap_cnt <= '0;
        end else if (!expired) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wprot_block_gate.sv
module wprot_block_gate #(
    parameter int ADDR_W = 13,
    parameter int BLOCKS = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BLOCKS-1:0] mask,
    output logic              locked
);

    localparam int IDX_W = $clog2(BLOCKS);

    logic [IDX_W-1:0]  blk_idx;
    logic [BLOCKS-1:0] blk_sel;

    assign blk_idx = addr[ADDR_W-1 -: IDX_W];

    for (genvar g = 0; g < BLOCKS; g++) begin : g_blk
        assign blk_sel[g] = (blk_idx == IDX_W'(g));
    end

    assign locked = |(blk_sel & mask);

endmodule

// File: rtl/wprot_seq.sv
module wprot_seq
    import wprot_pkg::*;
#(
    parameter int              ADDR_W   = 13,
    parameter int              DATA_W   = 8,
    parameter int              BLOCKS   = 8,
    parameter int              WIN_CYC  = 64,
    parameter logic [BLOCKS-1:0] LOCK_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_permit,
    output logic [BLOCKS-1:0] lock_mask,
    output logic              prot_on
);

    seq_state_t        state_q;
    seq_state_t        state_n;
    cmd_hit_t          hit;
    logic              locked;
    logic              expired;
    logic              permit_n;
    logic              set_prot;
    logic              clr_prot;
    logic              load_mask;
    logic              permit_q;
    logic              prot_q;
    logic [BLOCKS-1:0] mask_q;

    // Outcome of a write judged as if the matcher were idle.
    seq_state_t        idle_next;
    logic              idle_permit;

    wprot_cmd_match #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_match (
        .addr (wr_addr),
        .data (wr_data),
        .hit  (hit)
    );

    wprot_block_gate #(
        .ADDR_W (ADDR_W),
        .BLOCKS (BLOCKS)
    ) u_gate (
        .addr   (wr_addr),
        .mask   (mask_q),
        .locked (locked)
    );

    wprot_gap_timer #(
        .WIN_CYC (WIN_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state_q != ST_IDLE),
        .wr_seen (wr_en),
        .expired (expired)
    );

    assign idle_next   = hit.start_lo ? ST_G1 : ST_IDLE;
    assign idle_permit = !hit.start_lo && !prot_q && !locked;

    always_comb begin
        state_n   = state_q;
        permit_n  = 1'b0;
        set_prot  = 1'b0;
        clr_prot  = 1'b0;
        load_mask = 1'b0;
        if (wr_en) begin
            unique case (state_q)
                ST_IDLE: begin
                    state_n  = idle_next;
                    permit_n = idle_permit;
                end
                ST_G1: begin
                    if (hit.second_hi) begin
                        state_n = ST_G2;
                    end else begin
                        state_n  = idle_next;
                        permit_n = idle_permit;
                    end
                end
                ST_G2: begin
                    if (hit.arm_lo) begin
                        state_n  = ST_ARMED;
                        set_prot = 1'b1;
                    end else if (hit.deact_lo) begin
                        state_n = ST_D3;
                    end else begin
                        state_n  = idle_next;
                        permit_n = idle_permit;
                    end
                end
                ST_ARMED: begin
                    if (hit.start_lo) begin
                        state_n = ST_L4;
                    end else begin
                        permit_n = !locked;
                    end
                end
                ST_L4: begin
                    if (hit.lock_hi) begin
                        state_n = ST_LOPEN;
                    end else begin
                        state_n  = idle_next;
                        permit_n = idle_permit;
                    end
                end
                ST_LOPEN: begin
                    state_n   = ST_IDLE;
                    load_mask = 1'b1;
                end
                ST_D3: begin
                    if (hit.start_lo) begin
                        state_n = ST_D4;
                    end else begin
                        state_n  = idle_next;
                        permit_n = idle_permit;
                    end
                end
                ST_D4: begin
                    if (hit.second_hi) begin
                        state_n = ST_D5;
                    end else begin
                        state_n  = idle_next;
                        permit_n = idle_permit;
                    end
                end
                ST_D5: begin
                    if (hit.final_lo) begin
                        state_n  = ST_IDLE;
                        clr_prot = 1'b1;
                    end else begin
                        state_n  = idle_next;
                        permit_n = idle_permit;
                    end
                end
                default: begin
                    state_n = ST_IDLE;
                end
            endcase
        end else if (expired) begin
            state_n = ST_IDLE;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            permit_q <= 1'b0;
            prot_q   <= 1'b0;
            mask_q   <= LOCK_RST;
        end else begin
            permit_q <= permit_n;
            if (set_prot) begin
                prot_q <= 1'b1;
            end else if (clr_prot) begin
                prot_q <= 1'b0;
            end
            if (load_mask) begin
                mask_q <= wr_data[BLOCKS-1:0];
            end
        end
    end

    assign wr_permit = permit_q;
    assign lock_mask = mask_q;
    assign prot_on   = prot_q;

endmodule

// File: rtl/wprot_seq_chk.sv
module wprot_seq_chk #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter int BLOCKS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_permit,
    input logic [BLOCKS-1:0] lock_mask,
    input logic              prot_on
);

    localparam int IDX_W = $clog2(BLOCKS);

    // R2
    permit_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_permit |-> $past(wr_en));

    // R9
    permit_unlocked_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_permit |-> !$past(lock_mask[wr_addr[ADDR_W-1 -: IDX_W]]));

    // R8
    mask_load_unstored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock_mask) |-> ($past(wr_en) && !wr_permit));

    // R4
    prot_rise_on_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> $past(wr_en && wr_addr[11:0] == 12'h555 && wr_data == 8'hA0));

    // R10
    prot_fall_on_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_on) |-> $past(wr_en && wr_addr[11:0] == 12'h555 && wr_data == 8'h20));

    // R4
    cmd_byte_unstored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[11:0] == 12'h555 && wr_data == 8'hA0) |=> !wr_permit);

endmodule

bind wprot_seq wprot_seq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BLOCKS (BLOCKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_permit (wr_permit),
    .lock_mask (lock_mask),
    .prot_on   (prot_on)
);

// File: tb/wprot_seq_bench.sv
module wprot_seq_bench;

    localparam int CLK_PER = 10;
    localparam int WIN     = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [12:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_permit;
    logic [7:0]  lock_mask;
    logic        prot_on;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    wprot_seq #(
        .ADDR_W  (13),
        .DATA_W  (8),
        .BLOCKS  (8),
        .WIN_CYC (WIN)
    ) u_wprot_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_permit (wr_permit),
        .lock_mask (lock_mask),
        .prot_on   (prot_on)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One write; returns the permit pulse seen after the taking edge.
    task automatic do_wr(input logic [12:0] a, input logic [7:0] d, output logic p);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        p = wr_permit;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input logic [12:0] a, input logic [7:0] d, input string req);
        logic p;
        do_wr(a, d, p);
        check(req, int'(p), 0);
    endtask

    task automatic data_wr(input logic [12:0] a, input string req, input int exp);
        logic p;
        do_wr(a, 8'h3C, p);
        check(req, int'(p), exp);
    endtask

    task automatic arm();
        cmd(13'h0555, 8'hAA, "R4 arm step1");
        cmd(13'h0AAA, 8'h55, "R4 arm step2");
        cmd(13'h0555, 8'hA0, "R4 arm step3");
    endtask

    task automatic open_lock(input logic [7:0] m);
        arm();
        cmd(13'h0555, 8'hAA, "R8 lock step4");
        cmd(13'h0AAA, 8'hC0, "R8 lock step5");
        cmd(13'h1234, m, "R8 mask write not stored");
        check("R8 mask loaded", int'(lock_mask), int'(m));
    endtask

    task automatic t_reset();
        check("R1 permit", int'(wr_permit), 0);
        check("R1 prot", int'(prot_on), 0);
        check("R1 mask", int'(lock_mask), 0);
    endtask

    task automatic t_plain();
        data_wr(13'h0123, "R2 plain write", 1);
        data_wr(13'h1FFF, "R2 plain write top", 1);
    endtask

    task automatic t_break();
        cmd(13'h0555, 8'hAA, "R4 start byte unstored");
        begin
            logic p;
            do_wr(13'h0AAA, 8'h12, p);
            check("R7 mismatch judged ordinary", int'(p), 1);
            do_wr(13'h0AAA, 8'h55, p);
            check("R7 matcher back in idle", int'(p), 1);
        end
        check("R7 prot unchanged", int'(prot_on), 0);
    endtask

    task automatic t_arm_bit12();
        cmd(13'h1555, 8'hAA, "R3 bit12 ignored step1");
        cmd(13'h0AAA, 8'h55, "R3 step2");
        cmd(13'h1555, 8'hA0, "R3 bit12 ignored step3");
        check("R4 prot set", int'(prot_on), 1);
        data_wr(13'h0200, "R4 window write", 1);
        idle(WIN - 2);
        data_wr(13'h1300, "R6 gap WIN-1 keeps window", 1);
        idle(WIN - 1);
        data_wr(13'h0201, "R6 R5 gap WIN closes window", 0);
        data_wr(13'h0202, "R5 protected outside window", 0);
    endtask

    task automatic t_lock();
        open_lock(8'h04);
        arm();
        data_wr(13'h0800, "R9 locked block2 in window", 0);
        data_wr(13'h0C00, "R9 unlocked block3 in window", 1);
    endtask

    task automatic t_deact();
        idle(WIN);
        cmd(13'h0555, 8'hAA, "R10 d1");
        cmd(13'h0AAA, 8'h55, "R10 d2");
        cmd(13'h0555, 8'h80, "R10 d3");
        cmd(13'h0555, 8'hAA, "R10 d4");
        cmd(13'h0AAA, 8'h55, "R10 d5");
        cmd(13'h0555, 8'h20, "R10 d6");
        check("R10 prot cleared", int'(prot_on), 0);
        check("R10 mask kept", int'(lock_mask), 8'h04);
        data_wr(13'h0900, "R9 locked with prot off", 0);
        data_wr(13'h1000, "R2 unlocked with prot off", 1);
    endtask

    task automatic t_bound();
        open_lock(8'h81);
        arm();
        data_wr(13'h1FFF, "R9 block7 last byte", 0);
        data_wr(13'h03FF, "R9 block0 last byte", 0);
        data_wr(13'h0400, "R9 block1 first byte", 1);
        data_wr(13'h1BFF, "R9 block6 last byte", 1);
        check("R4 prot still set", int'(prot_on), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_break();
        t_arm_bit12();
        t_lock();
        t_deact();
        t_bound();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule